// File: doc/BRIEF.md
# Hybrid Two-Level Translation Lookup Engine

This block answers the question "which translation entry covers this virtual address?" for a 48-bit virtual space. It holds two tag stores. The first is set-associative: 8 ways of 256 sets, and all of its entries use a single page size that is given with each lookup. The second is a small fully associative store of 64 entries, and each of those entries carries its own page size. Every entry describes an aligned pair of pages, one even and one odd. Its stored page-pair tag is taken from virtual address bits 47 down to 13.

A lookup presents a virtual address, the current address-space identifier and the shared page size. One cycle later the block returns a hit flag and a flat entry index. Set-associative entries are numbered way*256+set, and the fully associative entries follow at 2048 to 2111. A single write port loads one entry per cycle, addressed by that same flat index. The block does not check permissions and does not form physical addresses.

Top module: `tlb_hybrid_lookup`

## Requirements
- R1: After a synchronous reset every entry is absent, res_valid is 0, and every lookup misses until an entry is written.
- R2: res_valid is 1 exactly in the cycle after a cycle with lk_req=1. A miss returns res_hit=0 and res_idx=0.
- R3: The set-associative set index is bits [PS+8:PS+1] of the lookup address, with PS=lk_gps. A hit in way w of set s reports index w*256+s.
- R4: An entry's tag matches when lk_va[47:PS+1] equals the stored tag bits [34:PS-12]. Address bits below PS+1 are ignored, so both pages of the pair hit. PS must lie in 12..46.
- R5: An entry can hit only when its exist bit is 1, and only when its global bit is 1 or its stored ASID equals lk_asid.
- R6: A set-associative hit takes priority over any fully associative hit. Within the set-associative store the lowest way wins, and within the fully associative store the lowest entry wins.
- R7: Each fully associative entry k uses its own stored page size in the R4 comparison, and a hit reports index 2048+k.
- R8: A write at flat index i (0..2111) takes effect for lookups issued from the next cycle on. A lookup issued in the same cycle as a write sees the old contents. Writes with i >= 2112 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one entry this cycle |
| wr_idx | input | 12 | Flat index of the entry to write |
| wr_vppn | input | 35 | Page-pair tag (virtual address bits 47:13) |
| wr_ps | input | 6 | Page size exponent (used by fully associative entries) |
| wr_asid | input | 10 | Address-space identifier of the entry |
| wr_glob | input | 1 | Entry matches any ASID |
| wr_exist | input | 1 | Entry is present |
| lk_req | input | 1 | Lookup request |
| lk_va | input | 48 | Lookup virtual address |
| lk_asid | input | 10 | Current address-space identifier |
| lk_gps | input | 6 | Shared page size exponent for the set-associative store |
| res_valid | output | 1 | Result valid (one cycle after lk_req) |
| res_hit | output | 1 | Some entry matched |
| res_idx | output | 12 | Flat index of the winning entry, 0 on miss |

## Verification
The assertions assume that lk_req stays low while reset is asserted. They also assume that every page size, whether given on lk_gps or stored with a fully associative entry, lies between 12 and 46, so that the tag mask never reaches below bit 13. The stimulus keeps to these limits: it holds lk_req at zero through reset and uses only page sizes of 12, 14 and 21. Its addresses are chosen so that the set index, the odd/even page bit and the first compared bit each change in isolation.

// File: rtl/tlb_lk_pkg.sv
package tlb_lk_pkg;
    localparam int VA_W      = 48;
    localparam int ASID_W    = 10;
    localparam int PS_W      = 6;
    localparam int VPPN_LSB  = 13;
    localparam int VPPN_W    = VA_W - VPPN_LSB;

    typedef struct packed {
        logic [VPPN_W-1:0] vppn;
        logic [ASID_W-1:0] asid;
        logic              glob;
    } tlb_key_t;

    // Tag bits that take part in the compare for page size ps: the bits at or above ps+1.
    function automatic logic [VPPN_W-1:0] pair_mask(input logic [PS_W-1:0] ps);
        logic [VPPN_W-1:0] m;
        for (int i = 0; i < VPPN_W; i++) begin
            m[i] = (i + VPPN_LSB) > int'(ps);
        end
        return m;
    endfunction

    function automatic logic tag_hit(input logic [VPPN_W-1:0] vpg,
                                     input logic [PS_W-1:0]   ps,
                                     input tlb_key_t          k,
                                     input logic              present,
                                     input logic [ASID_W-1:0] cur_asid);
        return present && (k.glob || (k.asid == cur_asid)) &&
               (((vpg ^ k.vppn) & pair_mask(ps)) == '0);
    endfunction
endpackage

// File: rtl/tlb_sa_bank.sv
module tlb_sa_bank
    import tlb_lk_pkg::*;
#(
    parameter int WAYS = 8,
    parameter int SETS = 256,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WAY_W-1:0]  wr_way,
    input  logic [SET_W-1:0]  wr_set,
    input  tlb_key_t          wr_key,
    input  logic              wr_exist,
    input  logic [SET_W-1:0]  lk_set,
    input  logic [VPPN_W-1:0] lk_vpg,
    input  logic [PS_W-1:0]   lk_gps,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              any_hit,
    output logic [WAY_W-1:0]  hit_way
);
    logic [WAYS-1:0] way_hit;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        tlb_key_t        keys [SETS];
        logic [SETS-1:0] ex;
        logic            sel;

        assign sel = wr_en && (wr_way == WAY_W'(w));

        always_ff @(posedge clk) begin
            if (rst) begin
                ex <= '0;
            end else if (sel) begin
                ex[wr_set] <= wr_exist;
            end
        end

        always_ff @(posedge clk) begin
            if (sel) begin
                keys[wr_set] <= wr_key;
            end
        end

        always_comb begin
            way_hit[w] = tag_hit(lk_vpg, lk_gps, keys[lk_set], ex[lk_set], lk_asid);
        end
    end

    always_comb begin
        any_hit = 1'b0;
        hit_way = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (way_hit[i]) begin
                any_hit = 1'b1;
                hit_way = WAY_W'(i);
            end
        end
    end

    // R6: the reported way hits and no lower way hits
    a_r6_lowest_way: assert property (@(posedge clk) disable iff (rst)
        any_hit |-> (way_hit[hit_way] &&
                     ($countones(way_hit & ((WAYS'(1) << hit_way) - WAYS'(1))) == 0)));
endmodule

// File: rtl/tlb_fa_bank.sv
module tlb_fa_bank
    import tlb_lk_pkg::*;
#(
    parameter int N = 64,
    localparam int IW = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IW-1:0]     wr_ofs,
    input  tlb_key_t          wr_key,
    input  logic [PS_W-1:0]   wr_ps,
    input  logic              wr_exist,
    input  logic [VPPN_W-1:0] lk_vpg,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              any_hit,
    output logic [IW-1:0]     hit_ofs
);
    tlb_key_t        keys [N];
    logic [PS_W-1:0] sizes [N];
    logic [N-1:0]    ex;
    logic [N-1:0]    ent_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            ex <= '0;
        end else if (wr_en) begin
            ex[wr_ofs] <= wr_exist;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            keys[wr_ofs]  <= wr_key;
            sizes[wr_ofs] <= wr_ps;
        end
    end

    for (genvar k = 0; k < N; k++) begin : g_ent
        always_comb begin
            ent_hit[k] = tag_hit(lk_vpg, sizes[k], keys[k], ex[k], lk_asid);
        end
    end

    always_comb begin
        any_hit = 1'b0;
        hit_ofs = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (ent_hit[i]) begin
                any_hit = 1'b1;
                hit_ofs = IW'(i);
            end
        end
    end

    // R5: a hit always lands on a present entry
    a_r5_fa_present: assert property (@(posedge clk) disable iff (rst)
        any_hit |-> ex[hit_ofs]);
    // R6: no lower entry also hits
    a_r6_lowest_entry: assert property (@(posedge clk) disable iff (rst)
        any_hit |-> ($countones(ent_hit & ((N'(1) << hit_ofs) - N'(1))) == 0));
endmodule

// File: rtl/tlb_hybrid_lookup.sv
module tlb_hybrid_lookup
    import tlb_lk_pkg::*;
#(
    parameter int SA_WAYS = 8,
    parameter int SA_SETS = 256,
    parameter int FA_N    = 64,
    localparam int SET_W   = $clog2(SA_SETS),
    localparam int WAY_W   = $clog2(SA_WAYS),
    localparam int FA_W    = $clog2(FA_N),
    localparam int FA_BASE = SA_WAYS * SA_SETS,
    localparam int IDX_W   = $clog2(FA_BASE + FA_N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VPPN_W-1:0] wr_vppn,
    input  logic [PS_W-1:0]   wr_ps,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic              wr_glob,
    input  logic              wr_exist,
    input  logic              lk_req,
    input  logic [VA_W-1:0]   lk_va,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [PS_W-1:0]   lk_gps,
    output logic              res_valid,
    output logic              res_hit,
    output logic [IDX_W-1:0]  res_idx
);
    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } lk_res_t;

    tlb_key_t          key_in;
    logic              sa_we, fa_we;
    logic [FA_W-1:0]   fa_ofs;
    logic [SET_W-1:0]  lk_set;
    logic [VPPN_W-1:0] lk_vpg;
    logic              sa_any, fa_any;
    logic [WAY_W-1:0]  sa_way;
    logic [FA_W-1:0]   fa_hit_ofs;
    lk_res_t           nxt, res_q;
    logic              valid_q;

    assign key_in = '{vppn: wr_vppn, asid: wr_asid, glob: wr_glob};
    assign sa_we  = wr_en && (int'(wr_idx) < FA_BASE);
    assign fa_we  = wr_en && (int'(wr_idx) >= FA_BASE) && (int'(wr_idx) < FA_BASE + FA_N);
    assign fa_ofs = FA_W'(int'(wr_idx) - FA_BASE);
    assign lk_set = SET_W'(lk_va >> ({1'b0, lk_gps} + 7'd1));
    assign lk_vpg = lk_va[VA_W-1:VPPN_LSB];

    tlb_sa_bank #(.WAYS(SA_WAYS), .SETS(SA_SETS)) sa_i (
        .clk(clk), .rst(rst),
        .wr_en(sa_we), .wr_way(wr_idx[SET_W +: WAY_W]), .wr_set(wr_idx[SET_W-1:0]),
        .wr_key(key_in), .wr_exist(wr_exist),
        .lk_set(lk_set), .lk_vpg(lk_vpg), .lk_gps(lk_gps), .lk_asid(lk_asid),
        .any_hit(sa_any), .hit_way(sa_way)
    );

    tlb_fa_bank #(.N(FA_N)) fa_i (
        .clk(clk), .rst(rst),
        .wr_en(fa_we), .wr_ofs(fa_ofs), .wr_key(key_in), .wr_ps(wr_ps),
        .wr_exist(wr_exist),
        .lk_vpg(lk_vpg), .lk_asid(lk_asid),
        .any_hit(fa_any), .hit_ofs(fa_hit_ofs)
    );

    always_comb begin
        nxt = '0;
        if (lk_req) begin
            if (sa_any) begin
                nxt.hit = 1'b1;
                nxt.idx = IDX_W'({sa_way, lk_set});
            end else if (fa_any) begin
                nxt.hit = 1'b1;
                nxt.idx = IDX_W'(FA_BASE + int'(fa_hit_ofs));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            res_q   <= '0;
        end else begin
            valid_q <= lk_req;
            res_q   <= nxt;
        end
    end

    assign res_valid = valid_q;
    assign res_hit   = res_q.hit;
    assign res_idx   = res_q.idx;

    // R2: a result follows each request by exactly one cycle
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        lk_req |=> res_valid);
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !lk_req |=> !res_valid);
    // R2: a miss reports index zero
    a_r2_miss_zero: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_hit) |-> (res_idx == '0));
    // R6: a set-associative hit wins
    a_r6_sa_first: assert property (@(posedge clk) disable iff (rst)
        (lk_req && sa_any) |=> (res_hit && (int'(res_idx) < FA_BASE)));
    // R7: any reported index lies inside the populated index space
    a_r7_idx_range: assert property (@(posedge clk) disable iff (rst)
        res_hit |-> (int'(res_idx) < FA_BASE + FA_N));
    // R4: lookup page size within the supported range
    a_r4_gps_range: assert property (@(posedge clk) disable iff (rst)
        lk_req |-> ((lk_gps >= 6'd12) && (lk_gps <= 6'd46)));
endmodule

// File: tb/tlb_hybrid_lookup_tb_top.sv
module tlb_hybrid_lookup_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [11:0] wr_idx = '0;
    logic [34:0] wr_vppn = '0;
    logic [5:0]  wr_ps = 6'd14;
    logic [9:0]  wr_asid = '0;
    logic        wr_glob = 1'b0;
    logic        wr_exist = 1'b0;
    logic        lk_req = 1'b0;
    logic [47:0] lk_va = '0;
    logic [9:0]  lk_asid = '0;
    logic [5:0]  lk_gps = 6'd14;
    logic        res_valid, res_hit;
    logic [11:0] res_idx;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [12:0] exp_q [$];
    string       tag_q [$];

    always #10 clk = ~clk;

    tlb_hybrid_lookup dut_i (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_vppn(wr_vppn), .wr_ps(wr_ps),
        .wr_asid(wr_asid), .wr_glob(wr_glob), .wr_exist(wr_exist),
        .lk_req(lk_req), .lk_va(lk_va), .lk_asid(lk_asid), .lk_gps(lk_gps),
        .res_valid(res_valid), .res_hit(res_hit), .res_idx(res_idx)
    );

    function automatic int set_of(input logic [47:0] va, input int ps);
        return int'((va >> (ps + 1)) & 48'hFF);
    endfunction

    task automatic wr(input int idx, input logic [47:0] va, input int ps,
                      input int asid, input bit glob, input bit ex);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 12'(idx); wr_vppn = va[47:13]; wr_ps = 6'(ps);
        wr_asid = 10'(asid); wr_glob = glob; wr_exist = ex;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic look(input logic [47:0] va, input int asid, input int gps,
                        input bit ehit, input int eidx, input string tag);
        @(negedge clk);
        lk_req = 1'b1; lk_va = va; lk_asid = 10'(asid); lk_gps = 6'(gps);
        exp_q.push_back({ehit, 12'(eidx)});
        tag_q.push_back(tag);
        @(negedge clk);
        lk_req = 1'b0;
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && res_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL unexpected result hit=%0d idx=%0d expected no result", res_hit, res_idx);
            end else begin
                logic [12:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if ({res_hit, res_idx} !== e) begin
                    errors++;
                    $display("FAIL %s: got hit=%0d idx=%0d expected hit=%0d idx=%0d",
                             t, res_hit, res_idx, e[12], e[11:0]);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    localparam logic [47:0] VA_A = 48'h00AB_CD40_0000;
    localparam logic [47:0] VA_B = 48'h0000_3000_0000;
    localparam logic [47:0] VA_C = 48'h0000_0055_6000;
    localparam logic [47:0] VA_D = 48'h0000_7700_0000;
    localparam logic [47:0] VA_E = 48'h0000_9900_0000;

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        checks++;
        if (res_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: res_valid=%0d expected 0", res_valid);
        end
        look(VA_A, 5, 14, 0, 0, "R1 empty after reset");
        // R2: idle cycle produces no result
        @(negedge clk);
        checks++;
        if (res_valid !== 1'b0) begin
            errors++;
            $display("FAIL R2 idle: res_valid=%0d expected 0", res_valid);
        end

        // R3/R4: set-associative hit in way 3
        wr(3 * 256 + set_of(VA_A, 14), VA_A, 14, 5, 0, 1);
        look(VA_A, 5, 14, 1, 3 * 256 + set_of(VA_A, 14), "R3 way3 hit");
        look(VA_A | 48'h7ABC, 5, 14, 1, 3 * 256 + set_of(VA_A, 14), "R4 odd page of pair");
        look(VA_A ^ (48'h1 << 23), 5, 14, 0, 0, "R4 compared bit differs");
        // R5: ASID mismatch
        look(VA_A, 6, 14, 0, 0, "R5 asid mismatch");
        // R5/R6: global entry in way 1
        wr(1 * 256 + set_of(VA_A, 14), VA_A, 14, 9, 1, 1);
        look(VA_A, 6, 14, 1, 1 * 256 + set_of(VA_A, 14), "R5 global entry");
        look(VA_A, 5, 14, 1, 1 * 256 + set_of(VA_A, 14), "R6 lowest way wins");
        wr(1 * 256 + set_of(VA_A, 14), VA_A, 14, 9, 1, 0);
        look(VA_A, 6, 14, 0, 0, "R5 cleared exist bit");
        look(VA_A, 5, 14, 1, 3 * 256 + set_of(VA_A, 14), "R5 way3 still present");

        // R3: smaller shared page size changes the set index
        wr(set_of(VA_C, 12), VA_C, 12, 5, 0, 1);
        look(VA_C, 5, 12, 1, set_of(VA_C, 12), "R3 gps12 set index");
        look(VA_C, 5, 14, 0, 0, "R3 gps14 other set");

        // R7: fully associative entry with its own 2 MiB page
        wr(2048 + 10, VA_B, 21, 5, 0, 1);
        look(VA_B + 48'h12345, 5, 14, 1, 2058, "R7 own page size");
        look(VA_B | (48'h1 << 21), 5, 14, 1, 2058, "R7 odd page of pair");
        look(VA_B ^ (48'h1 << 22), 5, 14, 0, 0, "R7 first compared bit");
        wr(2048 + 3, VA_B, 21, 0, 1, 1);
        look(VA_B, 5, 14, 1, 2051, "R6 lowest FA entry");
        wr(5 * 256 + set_of(VA_B, 14), VA_B, 14, 5, 0, 1);
        look(VA_B, 5, 14, 1, 5 * 256 + set_of(VA_B, 14), "R6 SA before FA");

        // R8: out-of-range writes change nothing
        wr(2112, VA_D, 14, 7, 1, 1);
        wr(4095, VA_D, 14, 7, 1, 1);
        look(VA_D, 7, 14, 0, 0, "R8 out of range write");

        // R8: same-cycle write and lookup sees old contents
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 12'(2068); wr_vppn = VA_E[47:13]; wr_ps = 6'd14;
        wr_asid = 10'd5; wr_glob = 1'b0; wr_exist = 1'b1;
        lk_req = 1'b1; lk_va = VA_E; lk_asid = 10'd5; lk_gps = 6'd14;
        exp_q.push_back({1'b0, 12'd0});
        tag_q.push_back("R8 same cycle old contents");
        @(negedge clk);
        wr_en = 1'b0; lk_req = 1'b0;
        look(VA_E, 5, 14, 1, 2068, "R8 write visible next cycle");

        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R2 missing results: %0d pending expected 0", exp_q.size());
        end
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule